// File: doc/BRIEF.md
# Three-Stage Dependency Token Controller

This block takes a stream of accelerator instructions and hands each one to one of three execution stages: a fetch stage that brings operands in, a compute stage, and a write-back stage. Each stage keeps its own FIFO of instructions. The opcode, and for loads the target memory, decide which FIFO an instruction enters. Inside one stage, instructions issue in arrival order. The stages run independently of each other. The only thing that orders them is dependency tokens, which move between neighbouring stages over four counters: fetch→compute, compute→fetch, compute→writeback and writeback→compute.

Every instruction carries four flags: pop-prev, pop-next, push-prev and push-next. A stage offers its head instruction for issue only when each token channel that instruction must pop holds at least one token. The tokens are taken at the moment of issue. Each stage has at most one instruction in flight. When the execution unit reports completion, the controller adds the tokens that the instruction's push flags request. Completing a FINISH instruction raises a sticky done flag. The execution units themselves sit outside this block.

Top module: `dep_token_ctrl`

## Requirements
- R1: Opcodes GEMM (2), ALU (4), FINISH (3) and any unlisted opcode (5, 6, 7) go to the compute stage (index 1). So does a LOAD (opcode 0) whose memory type is micro-op (0) or accumulator (3).
- R2: A LOAD whose memory type is weight (1) or input (2) goes to the fetch stage (index 0). STORE (opcode 1) goes to the writeback stage (index 2). An instruction issues with the tag and opcode it entered with.
- R3: A stage raises its issue valid when all of these hold: its FIFO is not empty, it has nothing in flight, and every channel its head must pop is non-zero. Otherwise it holds the head. Each issue takes one token from each required channel. Flag bits are: bit0 pop-prev, bit1 pop-next, bit2 push-prev, bit3 push-next.
- R4: In the compute stage, pop-prev reads fetch→compute, pop-next reads writeback→compute, push-prev feeds compute→fetch and push-next feeds compute→writeback.
- R5: The fetch stage pops compute→fetch through pop-next and pushes fetch→compute through push-next. The writeback stage pops compute→writeback through pop-prev and pushes writeback→compute through push-prev. Flags that point at a neighbour the stage does not have are ignored.
- R6: A completion pulse on a stage with an instruction in flight adds the requested tokens. A waiting consumer can issue from the next cycle.
- R7: done rises in the cycle after a FINISH completes. It stays high until clear or reset.
- R8: A channel saturates at 2^CW-1. A push into a full channel with no pop in the same cycle sets ovf_err, which stays set. A push and a pop on one channel in the same cycle leave its count unchanged.
- R9: in_ready is low while the FIFO of the target stage is full. Each stage keeps its instructions in arrival order.
- R10: A synchronous clr empties every FIFO and channel, drops in-flight state, done and ovf_err, and holds in_ready and all issue valids low.
- R11: While a stage has an instruction in flight it offers no further issue. A completion pulse on an idle stage has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all state |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when both are high |
| in_op | input | 3 | Opcode |
| in_mem | input | 2 | Memory type for LOAD |
| in_flags | input | 4 | Dependency flags |
| in_tag | input | TAGW | Instruction identifier carried to the stage |
| iss_valid | output | 3 | Per stage: head may issue |
| iss_ready | input | 3 | Per stage: execution unit takes the head |
| iss_op | output | 9 | Per stage opcode, stage s at bits 3s+2..3s |
| iss_tag | output | 3*TAGW | Per stage tag, stage s at slice s |
| cpl_valid | input | 3 | Per stage completion pulse |
| done | output | 1 | Sticky FINISH-completed flag |
| ovf_err | output | 1 | Sticky token overflow error |

## Verification
in_ready and the issue valids follow combinationally from the current state and the current inputs. They are therefore checked in the same cycle the stimulus is driven, 2 ns after the falling edge. Token counts, FIFO contents, in-flight state, done and ovf_err change at the rising edge after their cause, so their effects show up at the next sample point. The bench keeps a model that is updated once per cycle with exactly the inputs driven in that cycle, and compares the outputs against the model before each update. That alignment keeps every check on the correct cycle. Directed sequences cover stalls, ignored edge flags, saturation, FINISH and clear. Seeded random traffic covers everything else.

// File: rtl/dep_pkg.sv
package dep_pkg;
    localparam logic [2:0] OP_LOAD   = 3'd0;
    localparam logic [2:0] OP_STORE  = 3'd1;
    localparam logic [2:0] OP_GEMM   = 3'd2;
    localparam logic [2:0] OP_FINISH = 3'd3;
    localparam logic [2:0] OP_ALU    = 3'd4;

    localparam logic [1:0] MEM_UOP = 2'd0;
    localparam logic [1:0] MEM_WGT = 2'd1;
    localparam logic [1:0] MEM_INP = 2'd2;
    localparam logic [1:0] MEM_ACC = 2'd3;

    localparam int FL_POPP  = 0;
    localparam int FL_POPN  = 1;
    localparam int FL_PUSHP = 2;
    localparam int FL_PUSHN = 3;

    localparam int NST = 3;
    localparam int NCH = 4;
    localparam int CH_F2C = 0;
    localparam int CH_C2F = 1;
    localparam int CH_C2W = 2;
    localparam int CH_W2C = 3;

    typedef enum logic [1:0] {
        STG_FETCH = 2'd0,
        STG_COMP  = 2'd1,
        STG_WB    = 2'd2
    } stage_e;

    function automatic stage_e route_of(input logic [2:0] op, input logic [1:0] mem);
        stage_e r;
        r = STG_COMP;
        if (op == OP_STORE) r = STG_WB;
        else if (op == OP_LOAD && (mem == MEM_WGT || mem == MEM_INP)) r = STG_FETCH;
        return r;
    endfunction
endpackage

// File: rtl/dep_fifo.sv
module dep_fifo #(
    parameter int DW    = 15,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULLN = CNTW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]   wp;
        logic [AW-1:0]   rp;
        logic [CNTW-1:0] n;
    } fst_t;

    fst_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];

    assign empty = (st_q.n == '0);
    assign full  = (st_q.n == FULLN);
    assign rdata = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            if (pop)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            if (push && !pop) st_d.n = st_q.n + 1'b1;
            else if (pop && !push) st_d.n = st_q.n - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wp] <= wdata;
    end

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dep_token_chan.sv
module dep_token_chan #(
    parameter int CW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic avail,
    output logic ovf
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } cst_t;

    cst_t st_d, st_q;

    assign avail = (st_q.cnt != '0);
    assign ovf   = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (inc && !dec) begin
            if (st_q.cnt == CMAX) st_d.ovf = 1'b1;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec && !inc) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_pop_has_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> st_q.cnt != '0);
    assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && !clr) |=> st_q.cnt == $past(st_q.cnt));
    assert_full_push_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && !clr && st_q.cnt == CMAX) |=> st_q.ovf);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr) |=> st_q.ovf);
endmodule

// File: rtl/dep_token_ctrl.sv
module dep_token_ctrl
    import dep_pkg::*;
#(
    parameter int TAGW  = 8,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [2:0]            in_op,
    input  logic [1:0]            in_mem,
    input  logic [3:0]            in_flags,
    input  logic [TAGW-1:0]       in_tag,
    output logic [2:0]            iss_valid,
    input  logic [2:0]            iss_ready,
    output logic [8:0]            iss_op,
    output logic [3*TAGW-1:0]     iss_tag,
    input  logic [2:0]            cpl_valid,
    output logic                  done,
    output logic                  ovf_err
);
    localparam int IW = TAGW + 7;

    typedef struct packed {
        logic [NST-1:0] busy;
        logic [NST-1:0] pprev;
        logic [NST-1:0] pnext;
        logic [NST-1:0] fin;
        logic           done;
    } ctl_t;

    ctl_t st_d, st_q;

    stage_e          tgt;
    logic            in_fire;
    logic [NST-1:0]  f_empty, f_full, fire, cpl_ok, tok_ok;
    logic [IW-1:0]   f_rd   [NST];
    logic [3:0]      hd_fl  [NST];
    logic [2:0]      hd_op  [NST];
    logic [TAGW-1:0] hd_tag [NST];
    logic [NCH-1:0]  ch_inc, ch_dec, ch_avail, ch_ovf;

    assign tgt      = route_of(in_op, in_mem);
    assign in_ready = !clr && !f_full[tgt];
    assign in_fire  = in_valid && in_ready;

    for (genvar s = 0; s < NST; s++) begin : g_stage
        dep_fifo #(.DW(IW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .push  (in_fire && (tgt == stage_e'(s))),
            .wdata ({in_tag, in_op, in_flags}),
            .pop   (fire[s]),
            .rdata (f_rd[s]),
            .empty (f_empty[s]),
            .full  (f_full[s])
        );
        assign hd_fl[s]  = f_rd[s][3:0];
        assign hd_op[s]  = f_rd[s][6:4];
        assign hd_tag[s] = f_rd[s][IW-1:7];
        assign iss_valid[s] = !clr && !f_empty[s] && !st_q.busy[s] && tok_ok[s];
        assign iss_op[3*s +: 3]       = hd_op[s];
        assign iss_tag[TAGW*s +: TAGW] = hd_tag[s];

        assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
            fire[s] |=> !iss_valid[s]);
        assert_finish_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_ok[s] && st_q.fin[s] && !clr) |=> done);
    end

    assign fire   = iss_valid & iss_ready;
    assign cpl_ok = cpl_valid & st_q.busy;

    // Pop gating per stage; edge stages only look at their existing neighbour.
    always_comb begin
        tok_ok[STG_FETCH] = !hd_fl[STG_FETCH][FL_POPN] || ch_avail[CH_C2F];
        tok_ok[STG_COMP]  = (!hd_fl[STG_COMP][FL_POPP] || ch_avail[CH_F2C]) &&
                            (!hd_fl[STG_COMP][FL_POPN] || ch_avail[CH_W2C]);
        tok_ok[STG_WB]    = !hd_fl[STG_WB][FL_POPP] || ch_avail[CH_C2W];
    end

    always_comb begin
        ch_dec[CH_F2C] = fire[STG_COMP]  && hd_fl[STG_COMP][FL_POPP];
        ch_dec[CH_W2C] = fire[STG_COMP]  && hd_fl[STG_COMP][FL_POPN];
        ch_dec[CH_C2F] = fire[STG_FETCH] && hd_fl[STG_FETCH][FL_POPN];
        ch_dec[CH_C2W] = fire[STG_WB]    && hd_fl[STG_WB][FL_POPP];
        ch_inc[CH_C2F] = cpl_ok[STG_COMP]  && st_q.pprev[STG_COMP];
        ch_inc[CH_C2W] = cpl_ok[STG_COMP]  && st_q.pnext[STG_COMP];
        ch_inc[CH_F2C] = cpl_ok[STG_FETCH] && st_q.pnext[STG_FETCH];
        ch_inc[CH_W2C] = cpl_ok[STG_WB]    && st_q.pprev[STG_WB];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dep_token_chan #(.CW(CW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (ch_inc[c]),
            .dec   (ch_dec[c]),
            .avail (ch_avail[c]),
            .ovf   (ch_ovf[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            for (int s = 0; s < NST; s++) begin
                if (cpl_ok[s]) begin
                    st_d.busy[s] = 1'b0;
                    if (st_q.fin[s]) st_d.done = 1'b1;
                end
                if (fire[s]) begin
                    st_d.busy[s]  = 1'b1;
                    st_d.pprev[s] = hd_fl[s][FL_PUSHP];
                    st_d.pnext[s] = hd_fl[s][FL_PUSHN];
                    st_d.fin[s]   = (hd_op[s] == OP_FINISH);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done    = st_q.done;
    assign ovf_err = |ch_ovf;

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (iss_valid == '0) && !done && !ovf_err);
endmodule

// File: tb/dep_token_ctrl_test.sv
module dep_token_ctrl_test;
    localparam int TAGW  = 8;
    localparam int DEPTH = 4;
    localparam int CW    = 3;
    localparam int MAXC  = (1 << CW) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0, in_ready;
    logic [2:0] in_op = '0;
    logic [1:0] in_mem = '0;
    logic [3:0] in_flags = '0;
    logic [TAGW-1:0] in_tag = '0;
    logic [2:0] iss_valid, iss_ready = '0, cpl_valid = '0;
    logic [8:0] iss_op;
    logic [3*TAGW-1:0] iss_tag;
    logic done, ovf_err;

    dep_token_ctrl #(.TAGW(TAGW), .DEPTH(DEPTH), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_mem(in_mem), .in_flags(in_flags), .in_tag(in_tag),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_tag(iss_tag),
        .cpl_valid(cpl_valid), .done(done), .ovf_err(ovf_err)
    );

    // model: entry = {tag, op, flags}
    logic [TAGW+6:0] mq [3][$];
    int tok [4];
    bit busy [3];
    bit [3:0] bfl [3];
    bit bfin [3];
    bit mdone, movf;
    int n_cmp = 0, n_bad = 0;
    logic [TAGW-1:0] next_tag = '0;
    string cur = "";
    bit finished = 0;

    function automatic int route(input logic [2:0] op, input logic [1:0] mem);
        if (op == 3'd1) return 2;
        if (op == 3'd0 && (mem == 2'd1 || mem == 2'd2)) return 0;
        return 1;
    endfunction

    function automatic bit tok_ok(input int s, input logic [3:0] f);
        if (s == 0) return !f[1] || tok[1] > 0;
        if (s == 1) return (!f[0] || tok[0] > 0) && (!f[1] || tok[3] > 0);
        return !f[0] || tok[2] > 0;
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic string lab(input string dflt);
        return (cur == "") ? dflt : cur;
    endfunction

    task automatic step();
        bit exp_rdy;
        bit ev [3];
        bit fire [3], cok [3];
        bit inc [4], dec [4];
        #2;
        exp_rdy = !clr && mq[route(in_op, in_mem)].size() < DEPTH;
        chk(lab("R9"), "in_ready", in_ready, exp_rdy);
        for (int s = 0; s < 3; s++) begin
            ev[s] = !clr && mq[s].size() > 0 && !busy[s] && tok_ok(s, mq[s][0][3:0]);
            chk(lab("R3"), $sformatf("iss_valid[%0d]", s), iss_valid[s], ev[s]);
            if (ev[s] && iss_valid[s]) begin
                chk(lab(s == 1 ? "R1" : "R2"), $sformatf("iss_tag[%0d]", s),
                    iss_tag[TAGW*s +: TAGW], mq[s][0][TAGW+6:7]);
                chk(lab(s == 1 ? "R1" : "R2"), $sformatf("iss_op[%0d]", s),
                    iss_op[3*s +: 3], mq[s][0][6:4]);
            end
        end
        chk(lab("R7"), "done", done, mdone);
        chk(lab("R8"), "ovf_err", ovf_err, movf);
        if (clr) begin
            for (int s = 0; s < 3; s++) begin mq[s].delete(); busy[s] = 0; end
            for (int c = 0; c < 4; c++) tok[c] = 0;
            mdone = 0; movf = 0;
        end else begin
            for (int s = 0; s < 3; s++) begin
                fire[s] = ev[s] && iss_ready[s];
                cok[s]  = cpl_valid[s] && busy[s];
            end
            dec[0] = fire[1] && mq[1][0][0];
            dec[3] = fire[1] && mq[1][0][1];
            dec[1] = fire[0] && mq[0][0][1];
            dec[2] = fire[2] && mq[2][0][0];
            inc[1] = cok[1] && bfl[1][2];
            inc[2] = cok[1] && bfl[1][3];
            inc[0] = cok[0] && bfl[0][3];
            inc[3] = cok[2] && bfl[2][2];
            for (int c = 0; c < 4; c++) begin
                if (inc[c] && !dec[c]) begin
                    if (tok[c] == MAXC) movf = 1; else tok[c]++;
                end else if (dec[c] && !inc[c]) tok[c]--;
            end
            for (int s = 0; s < 3; s++) begin
                if (cok[s]) begin
                    if (bfin[s]) mdone = 1;
                    busy[s] = 0;
                end
                if (fire[s]) begin
                    bfl[s] = mq[s][0][3:0];
                    bfin[s] = (mq[s][0][6:4] == 3'd3);
                    busy[s] = 1;
                    void'(mq[s].pop_front());
                end
            end
            if (in_valid && exp_rdy) mq[route(in_op, in_mem)].push_back({in_tag, in_op, in_flags});
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic put(input logic [2:0] op, input logic [1:0] mem, input logic [3:0] fl);
        in_valid = 1; in_op = op; in_mem = mem; in_flags = fl; in_tag = next_tag;
        next_tag = next_tag + 1'b1;
        step();
        in_valid = 0;
    endtask

    task automatic do_clr();
        clr = 1; step(); clr = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur = "R10"; run(2);

        // R1 / R2 routing, drained with always-ready units
        cur = "R2"; iss_ready = 3'b111; cpl_valid = 3'b111;
        put(3'd0, 2'd2, 4'h0); put(3'd0, 2'd1, 4'h0); put(3'd1, 2'd0, 4'h0);
        cur = "R1";
        put(3'd0, 2'd0, 4'h0); put(3'd0, 2'd3, 4'h0); put(3'd2, 2'd0, 4'h0);
        put(3'd4, 2'd0, 4'h0); put(3'd6, 2'd0, 4'h0); put(3'd7, 2'd1, 4'h0);
        run(12);

        // R4 / R6: writeback waits on compute token, compute waits on writeback token
        cur = "R4"; do_clr();
        put(3'd1, 2'd0, 4'b0001); run(3);
        cur = "R6"; put(3'd2, 2'd0, 4'b1000); run(6);
        cur = "R4"; put(3'd2, 2'd0, 4'b0010); run(3);
        cur = "R6"; put(3'd1, 2'd0, 4'b0100); run(6);

        // R5: flags toward a missing neighbour are ignored
        cur = "R5"; do_clr();
        put(3'd0, 2'd2, 4'b0101); put(3'd1, 2'd0, 4'b1010); run(4);
        put(3'd2, 2'd0, 4'b0011); run(4);

        // R11: completion on idle stage ignored, busy blocks issue
        cur = "R11"; do_clr();
        iss_ready = 3'b000; cpl_valid = 3'b000;
        put(3'd2, 2'd0, 4'h0); put(3'd2, 2'd0, 4'h0);
        cpl_valid = 3'b010; run(2); cpl_valid = 3'b000;
        iss_ready = 3'b010; run(4);
        cpl_valid = 3'b010; run(1); cpl_valid = 3'b000; run(3);

        // R9: fill the fetch FIFO
        cur = "R9"; do_clr(); iss_ready = 3'b000;
        for (int i = 0; i < DEPTH + 2; i++) put(3'd0, 2'd1, 4'h0);
        iss_ready = 3'b001; cpl_valid = 3'b001; run(12);

        // R8: overflow fetch->compute
        cur = "R8"; do_clr();
        for (int i = 0; i < MAXC + 1; i++) begin put(3'd0, 2'd2, 4'b1000); run(2); end
        run(3);
        cur = "R10"; do_clr(); run(2);

        // R7: FINISH completion
        cur = "R7"; iss_ready = 3'b111; cpl_valid = 3'b000;
        put(3'd3, 2'd0, 4'h0); run(2); cpl_valid = 3'b010; run(2); cpl_valid = 3'b000; run(2);
        cur = "R10"; do_clr(); run(1);

        // random traffic
        cur = "";
        for (int i = 0; i < 20000; i++) begin
            in_valid  = ($urandom % 3) != 0;
            in_op     = 3'($urandom % 8);
            in_mem    = 2'($urandom % 4);
            in_flags  = 4'($urandom % 16);
            in_tag    = next_tag; next_tag = next_tag + 1'b1;
            iss_ready = 3'($urandom % 8);
            cpl_valid = 3'($urandom % 8);
            clr       = ($urandom % 300) == 0;
            step();
        end
        clr = 0; in_valid = 0;
        finished = 1;
        summary();
    end
endmodule